// File: doc/BRIEF.md
# D-PHY Data Lane Transmission Sequencer

This block sequences a single D-PHY data lane between its low-power idle and a high-speed burst. When a transmit request arrives while the lane rests in LP-11 and its exit hold has elapsed, the block drives the start-of-transmission walk. The line pair goes to LP-01 (Dp low, Dn high), then to LP-00 (both low), and then into high-speed mode. In high-speed mode it sends a zero preamble, one sync byte (0xB8) and the payload bytes it pulls from a byte source through a ready/valid handshake. After the payload it drives a trail pattern and then returns the lane to LP-11. There it holds an exit interval before it accepts the next request.

Every timed state lasts a programmable number of byte-clock cycles. The counts come from two packed configuration words. The words are sampled only while the lane rests in LP-11, so a burst always runs with the counts it started with. A zero count never removes a state from the sequence. The state is visited for one cycle, a collapse indication is raised for that cycle, and a sticky error flag records the event until reset. Analog drivers, serialisation to the bit rate and lane-to-lane skew lie outside this block.

Top module: `dphy_lane_seq`

## Requirements
- R1: During and after reset the lane shows LP-11 (lp_dp=1, lp_dn=1) with hs_en=0, hs_byte=0x00, tx_ready=0, collapse=0 and err_sticky=0.
- R2: An accepted request always produces LP-11, then LP-01 (lp_dp=0, lp_dn=1), then LP-00 (both 0), and only then hs_en=1. No state is skipped, even when its count is zero.
- R3: LP-01 lasts the link-entry count in cfg_lp_word[15:8] and LP-00 lasts the prepare count in cfg_hs_word[7:0], in clock cycles. A zero count lasts one cycle.
- R4: After LP-00, hs_en=1 with hs_byte=0x00 for the preamble count in cfg_hs_word[15:8] (zero lasts one cycle), followed by exactly one cycle of hs_byte=0xB8.
- R5: tx_ready is high in the sync cycle and in every payload cycle whose byte is not flagged last. A byte taken on tx_valid&tx_ready appears on hs_byte in the next cycle, in order. tx_last ends the payload. A ready cycle without tx_valid also ends it, and tx_valid while tx_ready is low is ignored.
- R6: The trail lasts the trail count in cfg_hs_word[23:16] (zero lasts one cycle), with hs_en=1 and all bits of hs_byte equal to the inverse of bit 7 of the last byte sent, which is the sync byte when there was no payload.
- R7: After the trail the lane returns to LP-11. With tx_req held, LP-01 begins after exactly max(E,1)+1 LP-11 cycles, where E is the exit count in cfg_lp_word[7:0].
- R8: The configuration words are sampled only in LP-11. Changing them after LP-01 has begun has no effect on any count of that burst, its exit hold included.
- R9: collapse is high during the single cycle of an LP-01, LP-00, preamble, trail or exit hold that was entered with a zero count, and low in every other cycle.
- R10: err_sticky rises with collapse and stays high until reset.
- R11: Outside the sync and payload cycles tx_ready is low, and whenever hs_en is low hs_byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Request to start a burst (level) |
| tx_valid | input | 1 | Payload byte valid |
| tx_data | input | DW | Payload byte |
| tx_last | input | 1 | Marks the final payload byte |
| tx_ready | output | 1 | Sequencer takes a byte this cycle |
| cfg_lp_word | input | REG_W | Link-entry count [15:8], exit count [7:0] |
| cfg_hs_word | input | REG_W | Trail count [23:16], preamble count [15:8], prepare count [7:0] |
| lp_dp | output | 1 | Low-power level of the positive line |
| lp_dn | output | 1 | Low-power level of the negative line |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | DW | Byte to the serialiser |
| collapse | output | 1 | Current timed state was entered with a zero count |
| err_sticky | output | 1 | A collapse has occurred since reset |

## Verification
The hardest situation to reach from the ports is a burst whose configuration words change after the start walk has begun. The sequencer has to keep its frozen counts all the way through the exit hold that follows the trail. The stimulus drives random words onto both configuration inputs in the first LP-01 cycle. The expected exit hold is then measured as the number of LP-11 cycles before the next LP-01, with tx_req held high from the first idle cycle. Collapsed states come from directed all-zero counts and from random counts that are zero one time in ten. Payload underruns, zero-length bursts and ignored bytes offered while ready is low are mixed into the random bursts.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

   typedef enum logic [2:0] {
      LN_IDLE  = 3'd0,
      LN_LP01  = 3'd1,
      LN_LP00  = 3'd2,
      LN_HSZ   = 3'd3,
      LN_SYNC  = 3'd4,
      LN_DATA  = 3'd5,
      LN_TRAIL = 3'd6
   } lane_st_e;

   localparam int NUM_FLD = 5;
   localparam int F_LPX   = 0;
   localparam int F_EXIT  = 1;
   localparam int F_PREP  = 2;
   localparam int F_ZERO  = 3;
   localparam int F_TRAIL = 4;

   // 0: field lives in the low-power word, 1: in the high-speed word
   function automatic int fld_word(input int f);
      return (f == F_LPX || f == F_EXIT) ? 0 : 1;
   endfunction

   // slot index of the field inside its word (slot * field width = lsb)
   function automatic int fld_slot(input int f);
      case (f)
         F_LPX:   return 1;
         F_EXIT:  return 0;
         F_PREP:  return 0;
         F_ZERO:  return 1;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/dphy_tim_snap.sv
module dphy_tim_snap
   import dphy_seq_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int FW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [REG_W-1:0] cfg_lp_word,
   input  logic [REG_W-1:0] cfg_hs_word,
   output logic [FW-1:0]    live_lpx,
   output logic [FW-1:0]    t_exit,
   output logic [FW-1:0]    t_prep,
   output logic [FW-1:0]    t_zero,
   output logic [FW-1:0]    t_trail
);
   localparam int LPX_LSB = fld_slot(F_LPX) * FW;

   logic [FW-1:0] snap [NUM_FLD];

   assign live_lpx = cfg_lp_word[LPX_LSB +: FW];

   for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
      localparam int LSB = fld_slot(k) * FW;
      logic [FW-1:0] raw;
      logic [FW-1:0] q;
      if (fld_word(k) == 0) begin : g_lp
         assign raw = cfg_lp_word[LSB +: FW];
      end else begin : g_hs
         assign raw = cfg_hs_word[LSB +: FW];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= '0;
         else if (sample_en) q <= raw;
      end
      assign snap[k] = q;
   end

   assign t_exit  = snap[F_EXIT];
   assign t_prep  = snap[F_PREP];
   assign t_zero  = snap[F_ZERO];
   assign t_trail = snap[F_TRAIL];

endmodule

// File: rtl/dphy_seq_fsm.sv
module dphy_seq_fsm
   import dphy_seq_pkg::*;
#(
   parameter int          FW   = 8,
   parameter int          DW   = 8,
   parameter logic [DW-1:0] SYNC = 8'hB8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_req,
   input  logic          tx_valid,
   input  logic [DW-1:0] tx_data,
   input  logic          tx_last,
   input  logic [FW-1:0] live_lpx,
   input  logic [FW-1:0] t_exit,
   input  logic [FW-1:0] t_prep,
   input  logic [FW-1:0] t_zero,
   input  logic [FW-1:0] t_trail,
   output lane_st_e      st,
   output logic [DW-1:0] data_q,
   output logic          tx_ready,
   output logic          sample_en,
   output logic          collapse,
   output logic          err_sticky
);
   lane_st_e      st_d;
   logic [FW-1:0] rem_q, rem_d;
   logic          busy_q, busy_d;
   logic [DW-1:0] data_d;
   logic          last_q, last_d;
   logic          zero_hit;

   function automatic logic [FW-1:0] hold_of(input logic [FW-1:0] c);
      return (c == '0) ? '0 : c - 1'b1;
   endfunction

   always_comb begin
      st_d     = st;
      rem_d    = rem_q;
      busy_d   = busy_q;
      data_d   = data_q;
      last_d   = last_q;
      zero_hit = 1'b0;
      case (st)
         LN_IDLE: begin
            if (busy_q) begin
               if (rem_q == '0) busy_d = 1'b0;
               else             rem_d  = rem_q - 1'b1;
            end else if (tx_req) begin
               st_d     = LN_LP01;
               rem_d    = hold_of(live_lpx);
               zero_hit = (live_lpx == '0);
            end
         end
         LN_LP01: begin
            if (rem_q != '0) rem_d = rem_q - 1'b1;
            else begin
               st_d     = LN_LP00;
               rem_d    = hold_of(t_prep);
               zero_hit = (t_prep == '0);
            end
         end
         LN_LP00: begin
            if (rem_q != '0) rem_d = rem_q - 1'b1;
            else begin
               st_d     = LN_HSZ;
               rem_d    = hold_of(t_zero);
               zero_hit = (t_zero == '0);
            end
         end
         LN_HSZ: begin
            if (rem_q != '0) rem_d = rem_q - 1'b1;
            else             st_d  = LN_SYNC;
         end
         LN_SYNC: begin
            if (tx_valid) begin
               st_d   = LN_DATA;
               data_d = tx_data;
               last_d = tx_last;
            end else begin
               st_d     = LN_TRAIL;
               data_d   = SYNC;
               rem_d    = hold_of(t_trail);
               zero_hit = (t_trail == '0);
            end
         end
         LN_DATA: begin
            if (last_q || !tx_valid) begin
               st_d     = LN_TRAIL;
               rem_d    = hold_of(t_trail);
               zero_hit = (t_trail == '0);
            end else begin
               data_d = tx_data;
               last_d = tx_last;
            end
         end
         LN_TRAIL: begin
            if (rem_q != '0) rem_d = rem_q - 1'b1;
            else begin
               st_d     = LN_IDLE;
               busy_d   = 1'b1;
               rem_d    = hold_of(t_exit);
               zero_hit = (t_exit == '0);
            end
         end
         default: st_d = LN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= LN_IDLE;
         rem_q      <= '0;
         busy_q     <= 1'b0;
         data_q     <= '0;
         last_q     <= 1'b0;
         collapse   <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         st         <= st_d;
         rem_q      <= rem_d;
         busy_q     <= busy_d;
         data_q     <= data_d;
         last_q     <= last_d;
         collapse   <= zero_hit;
         err_sticky <= err_sticky | zero_hit;
      end
   end

   assign tx_ready  = (st == LN_SYNC) || (st == LN_DATA && !last_q);
   assign sample_en = (st == LN_IDLE);

endmodule

// File: rtl/dphy_lane_drv.sv
module dphy_lane_drv
   import dphy_seq_pkg::*;
#(
   parameter int            DW      = 8,
   parameter logic [DW-1:0] SYNC    = 8'hB8,
   parameter bit            REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  lane_st_e      st,
   input  logic [DW-1:0] data_q,
   output logic          lp_dp,
   output logic          lp_dn,
   output logic          hs_en,
   output logic [DW-1:0] hs_byte
);
   logic          dp_c, dn_c, hs_c;
   logic [DW-1:0] byte_c;

   always_comb begin
      dp_c   = 1'b0;
      dn_c   = 1'b0;
      hs_c   = 1'b0;
      byte_c = '0;
      case (st)
         LN_IDLE:  begin dp_c = 1'b1; dn_c = 1'b1; end
         LN_LP01:  dn_c = 1'b1;
         LN_LP00:  ;
         LN_HSZ:   hs_c = 1'b1;
         LN_SYNC:  begin hs_c = 1'b1; byte_c = SYNC; end
         LN_DATA:  begin hs_c = 1'b1; byte_c = data_q; end
         LN_TRAIL: begin hs_c = 1'b1; byte_c = {DW{~data_q[DW-1]}}; end
         default:  begin dp_c = 1'b1; dn_c = 1'b1; end
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lp_dp   <= 1'b1;
            lp_dn   <= 1'b1;
            hs_en   <= 1'b0;
            hs_byte <= '0;
         end else begin
            lp_dp   <= dp_c;
            lp_dn   <= dn_c;
            hs_en   <= hs_c;
            hs_byte <= byte_c;
         end
      end
   end else begin : g_comb
      assign lp_dp   = dp_c;
      assign lp_dn   = dn_c;
      assign hs_en   = hs_c;
      assign hs_byte = byte_c;
   end

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
   import dphy_seq_pkg::*;
#(
   parameter int            REG_W   = 32,
   parameter int            FW      = 8,
   parameter int            DW      = 8,
   parameter logic [DW-1:0] SYNC    = 8'hB8,
   parameter bit            REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic             tx_valid,
   input  logic [DW-1:0]    tx_data,
   input  logic             tx_last,
   output logic             tx_ready,
   input  logic [REG_W-1:0] cfg_lp_word,
   input  logic [REG_W-1:0] cfg_hs_word,
   output logic             lp_dp,
   output logic             lp_dn,
   output logic             hs_en,
   output logic [DW-1:0]    hs_byte,
   output logic             collapse,
   output logic             err_sticky
);
   localparam int MAX_SLOT = 3;

   if (REG_W < MAX_SLOT * FW) begin : g_bad_regw
      $error("dphy_lane_seq: REG_W too narrow for three count fields");
   end
   if (FW < 1 || FW > 16) begin : g_bad_fw
      $error("dphy_lane_seq: FW must lie in 1..16");
   end
   if (DW < 2) begin : g_bad_dw
      $error("dphy_lane_seq: DW must be at least 2");
   end

   lane_st_e      st;
   logic [DW-1:0] data_q;
   logic          sample_en;
   logic [FW-1:0] live_lpx, t_exit, t_prep, t_zero, t_trail;

   dphy_tim_snap #(.REG_W(REG_W), .FW(FW)) u_snap (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_en   (sample_en),
      .cfg_lp_word (cfg_lp_word),
      .cfg_hs_word (cfg_hs_word),
      .live_lpx    (live_lpx),
      .t_exit      (t_exit),
      .t_prep      (t_prep),
      .t_zero      (t_zero),
      .t_trail     (t_trail)
   );

   dphy_seq_fsm #(.FW(FW), .DW(DW), .SYNC(SYNC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_req     (tx_req),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_last    (tx_last),
      .live_lpx   (live_lpx),
      .t_exit     (t_exit),
      .t_prep     (t_prep),
      .t_zero     (t_zero),
      .t_trail    (t_trail),
      .st         (st),
      .data_q     (data_q),
      .tx_ready   (tx_ready),
      .sample_en  (sample_en),
      .collapse   (collapse),
      .err_sticky (err_sticky)
   );

   dphy_lane_drv #(.DW(DW), .SYNC(SYNC), .REG_OUT(REG_OUT)) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .data_q  (data_q),
      .lp_dp   (lp_dp),
      .lp_dn   (lp_dn),
      .hs_en   (hs_en),
      .hs_byte (hs_byte)
   );

endmodule

// File: rtl/dphy_lane_seq_chk.sv
module dphy_lane_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_ready,
   input logic lp_dp,
   input logic lp_dn,
   input logic hs_en,
   input logic collapse,
   input logic err_sticky
);
   logic in_lp01, in_lp00;
   assign in_lp01 = !lp_dp &&  lp_dn && !hs_en;
   assign in_lp00 = !lp_dp && !lp_dn && !hs_en;

   AST_LP01_FROM_LP11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp01 && !$past(in_lp01)) |-> $past(lp_dp && lp_dn && !hs_en)); // R2

   AST_LP00_FROM_LP01: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lp00 && !$past(in_lp00)) |-> $past(in_lp01)); // R2

   AST_HS_FROM_LP00: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(in_lp00)); // R2

   AST_LP11_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_en) |-> (lp_dp && lp_dn)); // R7

   AST_READY_ONLY_HS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> hs_en); // R11

   AST_ERR_ON_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
      collapse |-> err_sticky); // R10

   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_sticky) |-> err_sticky); // R10

endmodule

bind dphy_lane_seq dphy_lane_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_ready   (tx_ready),
   .lp_dp      (lp_dp),
   .lp_dn      (lp_dn),
   .hs_en      (hs_en),
   .collapse   (collapse),
   .err_sticky (err_sticky)
);

// File: tb/tb_dphy_lane_seq.sv
module tb_dphy_lane_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam logic [7:0] SYNC_B = 8'hB8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_req = 1'b0;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_last = 1'b0;
   logic        tx_ready;
   logic [31:0] cfg_lp_word = '0;
   logic [31:0] cfg_hs_word = '0;
   logic        lp_dp, lp_dn, hs_en, collapse, err_sticky;
   logic [7:0]  hs_byte;

   dphy_lane_seq dut (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .cfg_lp_word(cfg_lp_word), .cfg_hs_word(cfg_hs_word),
      .lp_dp(lp_dp), .lp_dn(lp_dn), .hs_en(hs_en), .hs_byte(hs_byte),
      .collapse(collapse), .err_sticky(err_sticky)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_errs   = 0;
   int cyc      = 0;
   int exp_idle = 1;
   bit exp_err  = 1'b0;
   logic [7:0] pl [16];

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         n_errs++;
         $display("FAIL R2 watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
         summary();
         $finish;
      end
   end

   function automatic int eff(input int c);
      return (c == 0) ? 1 : c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s at cycle %0d: actual %04h expected %04h", req, cyc, act, exp);
      end
   endtask

   // packs {ready, collapse, dp, dn, hs_en, byte}
   task automatic exp_cyc(input bit dp, input bit dn, input bit hs, input logic [7:0] b,
                          input bit col, input bit rdy, input string req);
      logic [15:0] act, exp;
      act = {3'b0, tx_ready, collapse, lp_dp, lp_dn, hs_en, hs_byte};
      exp = {3'b0, rdy, col, dp, dn, hs, b};
      chk(act === exp, req, act, exp);
   endtask

   task automatic drive_byte(input int j, input int n);
      tx_valid = 1'b1;
      tx_data  = pl[j];
      tx_last  = (j == n - 1);
   endtask

   // entered at a negedge where the lane shows LP-11
   task automatic burst(input int lpx, input int ex, input int prep, input int zr, input int tr,
                        input int n, input int und, input bit scr);
      int idle;
      int k;
      bit going;
      logic [7:0] last_b;
      cfg_lp_word = {16'h0, lpx[7:0], ex[7:0]};
      cfg_hs_word = {8'h0, tr[7:0], zr[7:0], prep[7:0]};
      tx_req = 1'b1;
      idle = 1;
      forever begin
         @(negedge clk);
         if (!lp_dp && lp_dn) break;
         idle++;
         if (idle > 600) break;
      end
      tx_req = 1'b0;
      chk(idle == exp_idle, "R7 exit hold", idle[15:0], exp_idle[15:0]);
      if (scr) begin
         cfg_lp_word = $urandom;   // R8: must not disturb this burst
         cfg_hs_word = $urandom;
      end
      for (int i = 0; i < eff(lpx); i++) begin
         if (i > 0) @(negedge clk);
         exp_cyc(0, 1, 0, 8'h00, (lpx == 0), 0, "R3/R9 lp01");
      end
      for (int i = 0; i < eff(prep); i++) begin
         @(negedge clk);
         exp_cyc(0, 0, 0, 8'h00, (prep == 0), 0, "R3/R9 lp00");
      end
      for (int i = 0; i < eff(zr); i++) begin
         @(negedge clk);
         exp_cyc(0, 0, 1, 8'h00, (zr == 0), 0, "R4 preamble");
      end
      @(negedge clk);
      exp_cyc(0, 0, 1, SYNC_B, 0, 1, "R4 sync");
      last_b = SYNC_B;
      k = 0;
      going = (n > 0 && und != 0);
      if (going) drive_byte(0, n);
      else tx_valid = 1'b0;
      while (going) begin
         @(negedge clk);
         exp_cyc(0, 0, 1, pl[k], 0, !(k == n - 1), "R5 payload");
         last_b = pl[k];
         k++;
         if (k == n) begin
            tx_valid = 1'b1;          // R5: offered while ready is low, ignored
            tx_data  = ~pl[k-1];
            tx_last  = 1'b0;
            going    = 1'b0;
         end else if (k == und) begin
            tx_valid = 1'b0;          // R5 underrun ends payload
            going    = 1'b0;
         end else begin
            drive_byte(k, n);
         end
      end
      for (int i = 0; i < eff(tr); i++) begin
         @(negedge clk);
         tx_valid = 1'b0;
         exp_cyc(0, 0, 1, last_b[7] ? 8'h00 : 8'hFF, (tr == 0), 0, "R6 trail");
      end
      @(negedge clk);
      exp_cyc(1, 1, 0, 8'h00, (ex == 0), 0, "R7/R9/R11 back to lp11");
      exp_idle = eff(ex) + 1;
      if (lpx == 0 || prep == 0 || zr == 0 || tr == 0 || ex == 0) exp_err = 1'b1;
      chk(err_sticky == exp_err, "R10 sticky", {15'b0, err_sticky}, {15'b0, exp_err});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      exp_cyc(1, 1, 0, 8'h00, 0, 0, "R1 in reset");
      chk(err_sticky == 1'b0, "R1/R10 reset clears", {15'b0, err_sticky}, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_cyc(1, 1, 0, 8'h00, 0, 0, "R1 after reset");
      chk(err_sticky == 1'b0, "R1 err after reset", {15'b0, err_sticky}, 16'h0);
      exp_idle = 1;
      exp_err  = 1'b0;
   endtask

   function automatic int rnd_cnt();
      return ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 6));
   endfunction

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      exp_cyc(1, 1, 0, 8'h00, 0, 0, "R1 reset state");
      do_reset();

      // target counts, last byte bit7 = 1 -> trail 0x00
      pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56; pl[3] = 8'h9A;
      burst(3, 6, 3, 10, 4, 4, -1, 0);
      // last byte bit7 = 0 -> trail 0xFF
      pl[0] = 8'hF0; pl[1] = 8'h0F;
      burst(3, 6, 3, 10, 4, 2, -1, 0);
      // every count zero: each state visited once, collapse flagged
      pl[0] = 8'hC3; pl[1] = 8'h3C;
      burst(0, 0, 0, 0, 0, 2, -1, 0);
      // zero-length burst: trail follows sync byte
      burst(2, 3, 2, 6, 2, 0, -1, 0);
      // underrun after two of five bytes
      for (int i = 0; i < 5; i++) pl[i] = 8'h21 + 8'(i);
      burst(1, 2, 1, 3, 3, 5, 2, 0);
      // configuration scrambled mid-burst
      burst(4, 5, 2, 7, 3, 3, -1, 1);
      do_reset();
      burst(1, 1, 1, 1, 1, 1, -1, 0);

      for (int b = 0; b < 60; b++) begin
         int n, und;
         n = $urandom_range(0, 8);
         for (int i = 0; i < 16; i++) pl[i] = 8'($urandom);
         und = (n > 0 && $urandom_range(0, 4) == 0) ? int'($urandom_range(0, n - 1)) : -1;
         burst(rnd_cnt(), rnd_cnt(), rnd_cnt(), rnd_cnt(), rnd_cnt(), n, und, 1'($urandom_range(0, 1)));
      end

      summary();
      $finish;
   end

endmodule